// File: doc/BRIEF.md
# Main Clock Source Switch Controller

This block decides which clock drives the CPU. After reset the CPU runs from an always-running internal oscillator. Software can then hand the CPU over to a main system clock, which comes from a crystal oscillator or from a clock fed in from outside. The block holds the registers for that sequence and drives a select line into a glitch-free clock multiplexer.

Software first sets the main-clock mode register once. It then picks a stabilization wait length and clears the oscillator stop bit. When the stabilization status register shows that the wait has elapsed, it requests the main clock. In crystal mode the block refuses a request that comes before the selected wait has elapsed. In external-clock mode there is no wait. A status bit reports the source actually in use, once the handover has passed through the synchronizing stages.

The block runs entirely in the internal-oscillator clock domain. Each main-oscillator cycle arrives as a one-cycle pulse on `osc_tick_i`.

Top module: `mainclk_switch`

## Requirements
- R1: After reset, the register reads are: mode (address 0) reads 0x00, stop (address 2, bit 0) reads 1, clock select (address 3) reads 0x00, stabilization status (address 4) reads 0x00. `clk_sel_o` is 0.
- R2: The mode register at address 0 has three fields: bit 7 external-clock select, bit 6 main pin enable, bit 0 high-gain range. It takes the first write after reset. Every later write is ignored, and its readback keeps the first value.
- R3: Bits 7,6 = 0,1 select crystal operation and 1,1 select the external clock. With bit 6 at 0, a request for the main clock (address 3, bit 0 written 1) is always refused.
- R4: While stop is 1, the stabilization counter is held at zero. While stop is 0 and the main pin is enabled, the counter advances once per `osc_tick_i` pulse and saturates at its top threshold. Status bit k (address 4) is 1 once the count is at least 2^(BASE_EXP+k), so the bits fill from bit 0 upward.
- R5: In crystal mode, a request for the main clock is refused while status bit [wait select] is still 0. The wait select is address 1, bits 2:0.
- R6: In crystal mode, once that status bit is 1, the request is accepted. `clk_sel_o` and readback bit 0 of address 3 go to 1 on the clock edge that takes the write.
- R7: In external-clock mode, a request for the main clock is accepted as soon as stop is 0, without waiting. It is refused while stop is 1.
- R8: The active-source bit (address 3, bit 1) follows `clk_sel_o` exactly HANDOVER_STAGES clock edges later, for both directions.
- R9: A write that sets stop to 1 is ignored while the main clock is selected or still shown active. Stop reads back 0 and the stabilization status is kept.
- R10: A request for the internal oscillator (address 3, bit 0 written 0) is always accepted. After the handover completes, stop can be set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| osc_tick_i | input | 1 | One pulse per main-oscillator cycle |
| clk_sel_o | output | 1 | 1 selects the main clock at the glitch-free mux |

## Verification
The hardest case to reach is a request for the main clock that comes after the oscillator has started but before the selected wait has elapsed. Only a refused request proves the gate works. The bench makes the thresholds small by setting BASE_EXP to 2 and holds the tick input high. It then places one request on the cycle right after stop is cleared. It places a second request after a counted number of cycles that falls between the selected threshold and the next one, so that both the refusal and the thermometer pattern can be predicted. External-clock mode sits behind the write-once lock, so the bench reaches it through a fresh reset.

// File: rtl/mcs_pkg.sv
// Package: shared register addresses and the mode field layout for the
// main clock switch. Assumes an 8-bit register bus.
package mcs_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_WAIT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STOP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CSEL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

    localparam int MODE_EXT_BIT  = 7;
    localparam int MODE_PIN_BIT  = 6;
    localparam int MODE_GAIN_BIT = 0;

    typedef struct packed {
        logic ext_clk;
        logic pin_en;
        logic gain_hi;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_XTAL   = 2'b01,
        SRC_EXTCLK = 2'b11
    } src_kind_e;
endpackage

// File: rtl/mcs_stab_counter.sv
// Module: stabilization counter. It counts main-oscillator tick pulses while
// enabled and is held at zero while cleared. It saturates at the top
// threshold and reports a thermometer of the thresholds reached.
// Assumes osc ticks already arrive in the clk domain.
module mcs_stab_counter #(
    parameter int NSTEP    = 8,
    parameter int BASE_EXP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             count_en_i,
    input  logic             tick_i,
    output logic [NSTEP-1:0] thermo_o
);
    localparam int CW = BASE_EXP + NSTEP;
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CMAX = ONE << (CW - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks, clear while stopped, stop at the top threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (count_en_i && tick_i && cnt_q < CMAX) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    for (genvar k = 0; k < NSTEP; k++) begin : g_thr
        assign thermo_o[k] = (cnt_q >= (ONE << (BASE_EXP + k)));
    end

    p_cnt_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CMAX);
    p_thermo_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((thermo_o + 1'b1) & thermo_o) == '0);
    p_cnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !(count_en_i && tick_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/mcs_handover.sv
// Module: handover tracker. It delays the clock select through a chain of
// flops and reports the source that the CPU actually runs from.
// Assumes the glitch-free mux completes within the stage count.
module mcs_handover #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic active_main_o
);
    logic [STAGES-1:0] pipe_q;

    // Shift the select through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], sel_i};
        end
    end

    assign active_main_o = pipe_q[STAGES-1];

    p_active_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_main_o) |-> $past(sel_i));
    p_active_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_main_o) |-> !$past(sel_i));
endmodule

// File: rtl/mcs_regs.sv
// Module: register file and switch policy. It holds the write-once mode,
// the wait select, the stop bit and the clock select. It decides whether a
// request for the main clock and a stop write may take effect.
// Assumes one write per cycle.
module mcs_regs
    import mcs_pkg::*;
#(
    parameter int NSTEP = 8,
    localparam int SELW = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSTEP-1:0]  thermo_i,
    input  logic              active_main_i,
    output mode_t             mode_o,
    output logic [SELW-1:0]   wait_sel_o,
    output logic              stop_o,
    output logic              sel_main_o
);
    logic      mode_locked_q;
    mode_t     mode_q;
    logic [SELW-1:0] wait_q;
    logic      stop_q;
    logic      sel_q;
    src_kind_e kind;
    logic      main_ready;
    logic      stop_blocked;

    // Classify the configured main source from the mode fields.
    always_comb begin
        if (!mode_q.pin_en)      kind = SRC_NONE;
        else if (mode_q.ext_clk) kind = SRC_EXTCLK;
        else                     kind = SRC_XTAL;
    end

    // Decide whether the main clock may be selected now.
    always_comb begin
        case (kind)
            SRC_XTAL:   main_ready = !stop_q && thermo_i[wait_q];
            SRC_EXTCLK: main_ready = !stop_q;
            default:    main_ready = 1'b0;
        endcase
    end

    assign stop_blocked = sel_q || active_main_i;

    // Mode register: take only the first write after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q        <= '0;
            mode_locked_q <= 1'b0;
        end else if (wr_en_i && addr_i == A_MODE && !mode_locked_q) begin
            mode_q.ext_clk <= wdata_i[MODE_EXT_BIT];
            mode_q.pin_en  <= wdata_i[MODE_PIN_BIT];
            mode_q.gain_hi <= wdata_i[MODE_GAIN_BIT];
            mode_locked_q  <= 1'b1;
        end
    end

    // Wait select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (wr_en_i && addr_i == A_WAIT) begin
            wait_q <= wdata_i[SELW-1:0];
        end
    end

    // Stop bit: setting it is refused while the main clock is in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
        end else if (wr_en_i && addr_i == A_STOP) begin
            if (!wdata_i[0])        stop_q <= 1'b0;
            else if (!stop_blocked) stop_q <= 1'b1;
        end
    end

    // Clock select: returning to internal is free, main is gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (wr_en_i && addr_i == A_CSEL) begin
            if (!wdata_i[0])     sel_q <= 1'b0;
            else if (main_ready) sel_q <= 1'b1;
        end
    end

    assign mode_o     = mode_q;
    assign wait_sel_o = wait_q;
    assign stop_o     = stop_q;
    assign sel_main_o = sel_q;

    p_mode_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked_q |=> $stable(mode_q));
    p_no_main_without_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> mode_q.pin_en);
    p_xtal_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) && !mode_q.ext_clk |-> $past(thermo_i[wait_q]));
    p_main_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> $past(!stop_q));
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q || active_main_i) |-> !stop_q);
endmodule

// File: rtl/mainclk_switch.sv
// Module: top of the main clock source switch controller. It ties the
// register file, the stabilization counter and the handover tracker
// together and provides the combinational read mux.
// Assumes a single clock domain (internal oscillator).
module mainclk_switch
    import mcs_pkg::*;
#(
    parameter int NSTEP    = 8,
    parameter int BASE_EXP = 8,
    parameter int HANDOVER_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              osc_tick_i,
    output logic              clk_sel_o
);
    localparam int SELW = (NSTEP > 1) ? $clog2(NSTEP) : 1;

    mode_t            mode;
    logic [SELW-1:0]  wait_sel;
    logic             stop;
    logic             sel_main;
    logic             active_main;
    logic [NSTEP-1:0] thermo;

    mcs_regs #(.NSTEP(NSTEP)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .thermo_i      (thermo),
        .active_main_i (active_main),
        .mode_o        (mode),
        .wait_sel_o    (wait_sel),
        .stop_o        (stop),
        .sel_main_o    (sel_main)
    );

    mcs_stab_counter #(.NSTEP(NSTEP), .BASE_EXP(BASE_EXP)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (stop),
        .count_en_i (mode.pin_en),
        .tick_i     (osc_tick_i),
        .thermo_o   (thermo)
    );

    mcs_handover #(.STAGES(HANDOVER_STAGES)) u_hand (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_i         (sel_main),
        .active_main_o (active_main)
    );

    // Read mux over the register map.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_MODE: begin
                rdata_o[MODE_EXT_BIT]  = mode.ext_clk;
                rdata_o[MODE_PIN_BIT]  = mode.pin_en;
                rdata_o[MODE_GAIN_BIT] = mode.gain_hi;
            end
            A_WAIT: rdata_o[SELW-1:0]  = wait_sel;
            A_STOP: rdata_o[0]         = stop;
            A_CSEL: rdata_o[1:0]       = {active_main, sel_main};
            A_STAT: rdata_o[NSTEP-1:0] = thermo;
            default: rdata_o = '0;
        endcase
    end

    assign clk_sel_o = sel_main;

    p_sel_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_o) |-> $past(wr_en_i && addr_i == A_CSEL && wdata_i[0]));
    p_back_to_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_CSEL && !wdata_i[0]) |=> !clk_sel_o);
endmodule

// File: tb/mainclk_switch_test.sv
module mainclk_switch_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b1;
    logic       clk_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mainclk_switch #(.NSTEP(8), .BASE_EXP(2), .HANDOVER_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .osc_tick_i(tick), .clk_sel_o(clk_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        rd(3'd0, v); check("R1 mode", v, 8'h00);
        rd(3'd2, v); check("R1 stop", v, 8'h01);
        rd(3'd3, v); check("R1 csel", v, 8'h00);
        rd(3'd4, v); check("R1 stat", v, 8'h00);
        check("R1 clk_sel_o", {7'd0, clk_sel}, 8'h00);
    endtask

    task automatic t_write_once();
        logic [7:0] v;
        wr(3'd0, 8'h41);
        rd(3'd0, v); check("R2 first write", v, 8'h41);
        wr(3'd0, 8'hC0);
        rd(3'd0, v); check("R2 second write ignored", v, 8'h41);
    endtask

    task automatic t_crystal_switch();
        logic [7:0] v;
        wr(3'd1, 8'h03);
        rd(3'd4, v); check("R4 held while stopped", v, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h01);
        check("R5 early request refused", {7'd0, clk_sel}, 8'h00);
        cycles(42);
        rd(3'd4, v); check("R4 thermometer after ~45 ticks", v, 8'h0F);
        wr(3'd3, 8'h01);
        check("R6 request accepted", {7'd0, clk_sel}, 8'h01);
        rd(3'd3, v); check("R8 active not yet", v, 8'h01);
        cycles(1);
        rd(3'd3, v); check("R8 active after 1 edge", v, 8'h01);
        cycles(1);
        rd(3'd3, v); check("R8 active after 2 edges", v, 8'h03);
        wr(3'd2, 8'h01);
        rd(3'd2, v); check("R9 stop write ignored", v, 8'h00);
        rd(3'd4, v); check("R9 status kept", v[3:0], 4'hF);
    endtask

    task automatic t_return_internal();
        logic [7:0] v;
        wr(3'd3, 8'h00);
        check("R10 back to internal", {7'd0, clk_sel}, 8'h00);
        rd(3'd3, v); check("R8 active still main", v, 8'h02);
        cycles(2);
        rd(3'd3, v); check("R8 active cleared", v, 8'h00);
        wr(3'd2, 8'h01);
        rd(3'd2, v); check("R10 stop accepted", v, 8'h01);
        cycles(1);
        rd(3'd4, v); check("R4 cleared by stop", v, 8'h00);
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        wr(3'd2, 8'h00);
        cycles(600);
        rd(3'd4, v); check("R4 saturated all bits", v, 8'hFF);
    endtask

    task automatic t_external();
        logic [7:0] v;
        do_reset();
        wr(3'd0, 8'hC0);
        wr(3'd1, 8'h07);
        wr(3'd3, 8'h01);
        check("R7 refused while stopped", {7'd0, clk_sel}, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h01);
        check("R7 accepted without wait", {7'd0, clk_sel}, 8'h01);
        rd(3'd4, v); check("R7 wait not elapsed", v[7], 1'b0);
    endtask

    task automatic t_no_pin();
        do_reset();
        wr(3'd0, 8'h80);
        wr(3'd2, 8'h00);
        cycles(20);
        wr(3'd3, 8'h01);
        check("R3 pin disabled refuses main", {7'd0, clk_sel}, 8'h00);
    endtask

    initial begin
        t_reset_state();
        t_write_once();
        t_crystal_switch();
        t_return_internal();
        t_saturate();
        t_external();
        t_no_pin();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule